// File: doc/BRIEF.md
# Overclock Watchdog with Safe-Frequency Fallback

This block guards a programmable clock source against a system that hangs after it has been overclocked. Software picks where the running frequency code comes from: either the strap/hardware selection or the code held in the VCO programming registers. Software arms a watchdog, loads a timeout in seconds and must rewrite that timeout before the count runs out. If it does not, the block raises a sticky status flag. While the flag is set, the frequency-select output carries a stored safe code in place of the normal selection.

A free-running prescaler inside the block divides the core clock down to a one-second tick. Registers are reached through a simple parallel interface with a write strobe, a one-bit address and a combinational read path. Address 0 is the control byte and address 1 is the timeout byte.

Top module: `ocw_fallback`

## Requirements
- R1: After reset the control byte reads 00h, the timeout byte reads FFh, `fallback_o` is 0 and `fsel_o` equals `hw_fsel_i`.
- R2: Control bit 7 selects the frequency source when no fallback is active. 0 routes `hw_fsel_i` to `fsel_o` and 1 routes `vco_fsel_i`.
- R3: The timeout byte at address 1 reads back the last value written to it.
- R4: Control bit 0 enables the watchdog. Expiry happens on the (T+1)-th tick after arming with timeout T. Expiry sets status (control bit 1, read back as 1) and drives `fallback_o` high, and only on a tick.
- R5: While status is set, `fsel_o` carries the safe code from control bits [6:2], whatever the two source inputs and bit 7 hold.
- R6: Writing the timeout byte while the watchdog is enabled reloads the count with the written value. This write is the service operation.
- R7: Status stays set across further ticks. It is cleared by a control write with bit 1 = 1 (write-one-to-clear), or by a control write with bit 0 = 0.
- R8: A timeout of 0 expires on the first tick after arming.
- R9: When a service write and a tick fall on the same cycle, the reload wins and that tick is not counted.
- R10: While the watchdog is disabled, no tick counts down and status cannot become set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register address: 0 = control, 1 = timeout |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| hw_fsel_i | input | 5 | Frequency code from the hardware/byte-0 selection |
| vco_fsel_i | input | 5 | Frequency code from the VCO programming registers |
| fsel_o | output | 5 | Frequency code in force |
| fallback_o | output | 1 | High while the safe code overrides the selection |
| sec_tick_o | output | 1 | One-cycle pulse per prescaled second |

## Verification
The service write and the one-second tick can land in the same cycle. The bench provokes this by arming with a zero timeout, waiting for the cycle in which `sec_tick_o` is high, and issuing the timeout write in exactly that cycle. A correct design shows no fallback after that edge. It then falls back only after the reloaded count has run its full length, one tick later than the plain count would suggest.

// File: rtl/ocw_pkg.sv
package ocw_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned FSEL_W = 5;

  typedef struct packed {
    logic              src_vco;
    logic [FSEL_W-1:0] safe;
    logic              status;
    logic              en;
  } ctl_t;

  localparam logic ADDR_CTL = 1'b0;
  localparam logic ADDR_TMO = 1'b1;
endpackage

// File: rtl/ocw_prescaler.sv
module ocw_prescaler #(
  parameter int unsigned DIV = 33_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ocw_countdown.sv
module ocw_countdown #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         hold_i,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expire_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic         step;

  // reload has priority over any tick in the same cycle
  assign step     = en_i && tick_i && !hold_i && !load_i;
  assign expire_o = step && (cnt_q == '0);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '1;
    else if (load_i)               cnt_q <= load_val_i;
    else if (step && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/ocw_regs.sv
module ocw_regs
  import ocw_pkg::*;
#(
  parameter int unsigned TMO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  output ctl_t              ctl_o,
  output logic              load_o,
  output logic [TMO_W-1:0]  load_val_o,
  output logic              ctl_we_o,
  output logic [DATA_W-1:0] rdata_o
);
  ctl_t             ctl_q;
  ctl_t             wr_ctl;
  logic [TMO_W-1:0] tmo_q;
  logic             tmo_we;
  logic             status_d;

  assign wr_ctl   = ctl_t'(wdata_i);
  assign ctl_we_o = we_i && (addr_i == ADDR_CTL);
  assign tmo_we   = we_i && (addr_i == ADDR_TMO);

  // arming edge loads the stored timeout; service write loads the new one
  assign load_o     = (tmo_we && ctl_q.en) || (ctl_we_o && wr_ctl.en && !ctl_q.en);
  assign load_val_o = tmo_we ? wdata_i[TMO_W-1:0] : tmo_q;

  always_comb begin
    status_d = ctl_q.status;
    if (ctl_we_o && (!wr_ctl.en || wr_ctl.status)) status_d = 1'b0;
    if (expire_i)                                  status_d = 1'b1;
    if (!ctl_q.en && !(ctl_we_o && wr_ctl.en))     status_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      tmo_q <= '1;
    end else begin
      ctl_q.status <= status_d;
      if (ctl_we_o) begin
        ctl_q.en      <= wr_ctl.en;
        ctl_q.safe    <= wr_ctl.safe;
        ctl_q.src_vco <= wr_ctl.src_vco;
      end
      if (tmo_we) tmo_q <= wdata_i[TMO_W-1:0];
    end
  end

  assign ctl_o = ctl_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTL) rdata_o = DATA_W'(ctl_q);
    else                    rdata_o[TMO_W-1:0] = tmo_q;
  end
endmodule

// File: rtl/ocw_fsel_mux.sv
module ocw_fsel_mux
  import ocw_pkg::*;
(
  input  logic              fallback_i,
  input  logic              src_vco_i,
  input  logic [FSEL_W-1:0] safe_i,
  input  logic [FSEL_W-1:0] hw_i,
  input  logic [FSEL_W-1:0] vco_i,
  output logic [FSEL_W-1:0] fsel_o
);
  logic [FSEL_W-1:0] active;

  assign active = src_vco_i ? vco_i : hw_i;
  assign fsel_o = fallback_i ? safe_i : active;
endmodule

// File: rtl/ocw_fallback.sv
module ocw_fallback
  import ocw_pkg::*;
#(
  parameter int unsigned TICK_DIV = 33_000_000,
  parameter int unsigned TMO_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [FSEL_W-1:0] hw_fsel_i,
  input  logic [FSEL_W-1:0] vco_fsel_i,
  output logic [FSEL_W-1:0] fsel_o,
  output logic              fallback_o,
  output logic              sec_tick_o
);
  ctl_t             ctl;
  logic             cnt_load;
  logic [TMO_W-1:0] cnt_load_val;
  logic [TMO_W-1:0] cnt_q;
  logic             expire;
  logic             ctl_we;

  ocw_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (sec_tick_o)
  );

  ocw_regs #(.TMO_W(TMO_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .expire_i   (expire),
    .ctl_o      (ctl),
    .load_o     (cnt_load),
    .load_val_o (cnt_load_val),
    .ctl_we_o   (ctl_we),
    .rdata_o    (reg_rdata_o)
  );

  ocw_countdown #(.W(TMO_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctl.en),
    .hold_i     (ctl.status),
    .tick_i     (sec_tick_o),
    .load_i     (cnt_load),
    .load_val_i (cnt_load_val),
    .expire_o   (expire),
    .cnt_o      (cnt_q)
  );

  ocw_fsel_mux u_mux (
    .fallback_i (ctl.status),
    .src_vco_i  (ctl.src_vco),
    .safe_i     (ctl.safe),
    .hw_i       (hw_fsel_i),
    .vco_i      (vco_fsel_i),
    .fsel_o     (fsel_o)
  );

  assign fallback_o = ctl.status;
endmodule

// File: rtl/ocw_fallback_chk.sv
module ocw_fallback_chk #(
  parameter int unsigned TMO_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sec_tick_o,
  input logic             fallback_o,
  input logic             reg_we_i,
  input logic             reg_addr_i,
  input logic [7:0]       reg_wdata_i,
  input logic             cnt_load,
  input logic [TMO_W-1:0] cnt_q,
  input logic             en_q
);
  logic ctl_wr;
  assign ctl_wr = reg_we_i && (reg_addr_i == 1'b0);

  assert_expire_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fallback_o && !sec_tick_o |=> !fallback_o);

  assert_count_still_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_tick_o && !cnt_load |=> $stable(cnt_q));

  assert_status_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fallback_o && en_q && !(ctl_wr && (reg_wdata_i[1] || !reg_wdata_i[0])) |=> fallback_o);

  assert_no_expiry_disabled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !fallback_o);
endmodule

bind ocw_fallback ocw_fallback_chk #(.TMO_W(TMO_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sec_tick_o  (sec_tick_o),
  .fallback_o  (fallback_o),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .cnt_load    (cnt_load),
  .cnt_q       (cnt_q),
  .en_q        (ctl.en)
);

// File: tb/ocw_fallback_bench.sv
module ocw_fallback_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [4:0] hw = '0;
  logic [4:0] vco = '0;
  logic [4:0] fsel;
  logic       fb;
  logic       tick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  ocw_fallback #(.TICK_DIV(6)) u_ocw_fallback (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .hw_fsel_i   (hw),
    .vco_fsel_i  (vco),
    .fsel_o      (fsel),
    .fallback_o  (fb),
    .sec_tick_o  (tick)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      while (!tick) @(negedge clk);
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] ctl(input logic src, input logic [4:0] safe,
                                     input logic w1c, input logic en);
    return {src, safe, w1c, en};
  endfunction

  // {src, hw, vco, expected fsel}
  localparam logic [15:0] VEC [5] = '{
    {1'b0, 5'h03, 5'h1c, 5'h03},
    {1'b1, 5'h03, 5'h1c, 5'h1c},
    {1'b1, 5'h1f, 5'h00, 5'h00},
    {1'b0, 5'h1f, 5'h00, 5'h1f},
    {1'b1, 5'h0a, 5'h15, 5'h15}
  };

  initial begin
    logic [7:0] r;
    hw = 5'h07; vco = 5'h19;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, r); chk("R1 ctl reset", r, 8'h00);
    rd(1'b1, r); chk("R1 timeout reset", r, 8'hff);
    chk("R1 fallback reset", {7'd0, fb}, 8'h00);
    chk("R1 fsel reset", {3'd0, fsel}, {3'd0, hw});

    // R2 source select table
    for (int i = 0; i < 5; i++) begin
      hw = VEC[i][14:10]; vco = VEC[i][9:5];
      wr(1'b0, ctl(VEC[i][15], 5'h00, 1'b0, 1'b0));
      chk("R2 source select", {3'd0, fsel}, {3'd0, VEC[i][4:0]});
    end

    // R3 timeout readback
    wr(1'b1, 8'h5a); rd(1'b1, r); chk("R3 timeout readback", r, 8'h5a);

    // R10 disabled: no countdown even with zero timeout
    wr(1'b1, 8'h00);
    wait_ticks(3);
    chk("R10 no expiry when disabled", {7'd0, fb}, 8'h00);

    // R4 expiry after T+1 ticks, R5 safe override
    hw = 5'h04; vco = 5'h09;
    wr(1'b1, 8'h02);
    wr(1'b0, ctl(1'b1, 5'h15, 1'b0, 1'b1));
    wait_ticks(2);
    chk("R4 no expiry after T ticks", {7'd0, fb}, 8'h00);
    chk("R2 vco source while armed", {3'd0, fsel}, 8'h09);
    wait_ticks(1);
    chk("R4 expiry on tick T+1", {7'd0, fb}, 8'h01);
    rd(1'b0, r); chk("R4 status bit reads 1", {7'd0, r[1]}, 8'h01);
    chk("R5 safe code on fsel", {3'd0, fsel}, 8'h15);
    hw = 5'h1e; vco = 5'h11;
    wr(1'b0, ctl(1'b0, 5'h15, 1'b0, 1'b1));
    chk("R5 safe code ignores sources", {3'd0, fsel}, 8'h15);

    // R7 sticky, then write-one-to-clear
    wait_ticks(2);
    chk("R7 status sticky", {7'd0, fb}, 8'h01);
    wr(1'b0, ctl(1'b0, 5'h15, 1'b1, 1'b1));
    chk("R7 w1c clears status", {7'd0, fb}, 8'h00);
    chk("R7 fsel back to source", {3'd0, fsel}, 8'h1e);
    wait_ticks(1); // counter held at 0: expires again
    chk("R7 re-expire after clear", {7'd0, fb}, 8'h01);
    wr(1'b0, ctl(1'b0, 5'h15, 1'b0, 1'b0));
    chk("R7 disable clears status", {7'd0, fb}, 8'h00);

    // R6 service reloads
    wr(1'b1, 8'h02);
    wr(1'b0, ctl(1'b0, 5'h0c, 1'b0, 1'b1));
    wait_ticks(2);
    wr(1'b1, 8'h02);
    wait_ticks(2);
    chk("R6 service postpones expiry", {7'd0, fb}, 8'h00);
    wait_ticks(1);
    chk("R6 expiry after reloaded count", {7'd0, fb}, 8'h01);
    chk("R5 new safe code", {3'd0, fsel}, 8'h0c);
    wr(1'b0, 8'h00);

    // R8 zero timeout
    wr(1'b1, 8'h00);
    wr(1'b0, ctl(1'b0, 5'h03, 1'b0, 1'b1));
    chk("R8 armed, not yet expired", {7'd0, fb}, 8'h00);
    wait_ticks(1);
    chk("R8 zero timeout expires on first tick", {7'd0, fb}, 8'h01);
    wr(1'b0, 8'h00);

    // R9 service on the same cycle as the expiring tick
    wr(1'b1, 8'h00);
    wr(1'b0, ctl(1'b0, 5'h03, 1'b0, 1'b1));
    while (!tick) @(negedge clk);
    wr(1'b1, 8'h01);
    chk("R9 reload beats tick", {7'd0, fb}, 8'h00);
    wait_ticks(1);
    chk("R9 reloaded count running", {7'd0, fb}, 8'h00);
    wait_ticks(1);
    chk("R9 expiry after reload", {7'd0, fb}, 8'h01);
    rd(1'b1, r); chk("R3 timeout holds service value", r, 8'h01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule